// File: doc/BRIEF.md
# Transmit 67-to-40 Bit Lane Gearbox

This block sits between a lane's upstream word FIFO and the parallel input of its serial transmitter. It takes 67-bit encoded lane words and turns them into 40-bit parallel words. Each output word carries the next 40 bits of the incoming bit stream, with no gaps. One clock drives both sides. The ratio 67:40 is not an integer, so a new input word is needed on some cycles and not on others.

The input side is valid/ready. The gearbox raises `in_ready` only when it holds fewer than 40 bits, which is the only case where it needs more data to produce the next output. A word is taken on a cycle where `in_valid` and `in_ready` are both high. When `in_ready` is low, the producer must hold its word, and the block ignores `in_valid` and `in_data`. When `in_ready` is high and `in_valid` is low, nothing is taken.

The producer reads its FIFO faster than the FIFO fills on average, so empty cycles do occur. They cost no throughput as long as a word is present on every cycle where `in_ready` is high. If no word is present on such a cycle after streaming has begun, no output word can be formed. In that case the block skips one output slot and latches an underrun flag.

Top module: `lane_tx_gearbox`

## Requirements
- R1: After a synchronous reset (`rst` high at a clock edge), `out_valid` is 0, `underrun` is 0, `in_ready` is 1 and no bits are held.
- R2: `in_ready` is 1 exactly when fewer than 40 bits are held. A word is accepted only on a cycle with `in_valid` and `in_ready` both 1.
- R3: Output bit order: the output stream is the accepted words joined together, bit 0 of each word first. Bit 0 of `out_data` is the earliest bit of each output word. No bit is lost or repeated.
- R4: On any cycle where at least 40 bits are held, or where a word is accepted, a 40-bit word is produced. The word appears on `out_data`, with `out_valid` high, after the next clock edge.
- R5: The held bit count never exceeds 106. As a result, `in_ready` is never low for more than two cycles in a row.
- R6: While `in_ready` is 0, `in_valid` and `in_data` have no effect on the output stream. Before the first word is accepted, idle cycles produce no output and no underrun.
- R7: Once a word has been accepted, a cycle with `in_ready` 1 and `in_valid` 0 is an underrun. `out_valid` is 0 after that edge, the held bits are kept, and `underrun` goes to 1 and stays at 1 until reset.
- R8: If the producer offers a word on every cycle where `in_ready` is 1, `out_valid` stays 1 on every cycle after the first output.
- R9: A reset in the middle of a stream discards all held bits. The stream then restarts from the next accepted word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for both sides |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | An input word is offered |
| in_ready | output | 1 | The gearbox takes a word this cycle if one is offered |
| in_data | input | 67 | Encoded lane word, bit 0 sent first |
| out_valid | output | 1 | `out_data` holds a new 40-bit word |
| out_data | output | 40 | Parallel word to the transmitter, bit 0 first |
| underrun | output | 1 | Sticky: an output slot was missed for lack of input |

## Verification
The bench models the bit stream as a queue. It goes after the points where the 67-bit and 40-bit boundaries fall on the residue, from 0 up to 106 held bits. A shift by the wrong residue, or a carry mishandled at the remainder, would scramble or repeat bits in the output stream. It offers junk words while `in_ready` is low; a design that sampled them would splice foreign bits into the stream. It drops the valid flag on one ready cycle to force an underrun, and resets mid-stream. A design with a non-sticky flag, or one that consumed bits during a stall, or kept stale residue through reset, would miss the flag or shift every later word.

// File: rtl/gbx_pkg.sv
package gbx_pkg;
  parameter int GBX_IN_W  = 67;
  parameter int GBX_OUT_W = 40;
endpackage

// File: rtl/gbx_ctrl.sv
module gbx_ctrl #(
  parameter int IN_W  = 67,
  parameter int OUT_W = 40,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  output logic             take,
  output logic             emit,
  output logic [CNT_W-1:0] fill,
  output logic             out_valid,
  output logic             underrun
);
  localparam int MAX_FILL = IN_W + OUT_W - 1;

  logic             primed;
  logic             stall;
  logic [CNT_W-1:0] fill_nxt;

  always_comb begin
    in_ready = (fill < CNT_W'(OUT_W));
    take     = in_valid & in_ready;
    emit     = take | ~in_ready;
    stall    = primed & in_ready & ~in_valid;
    fill_nxt = fill;
    if (take) fill_nxt = fill_nxt + CNT_W'(IN_W);
    if (emit) fill_nxt = fill_nxt - CNT_W'(OUT_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      fill      <= '0;
      primed    <= 1'b0;
      out_valid <= 1'b0;
      underrun  <= 1'b0;
    end else begin
      fill      <= fill_nxt;
      out_valid <= emit;
      if (take)  primed   <= 1'b1;
      if (stall) underrun <= 1'b1;
    end
  end

  AST_FILL_MAX: assert property (@(posedge clk) disable iff (rst)
    fill <= CNT_W'(MAX_FILL)); // R5

  AST_FILL_STEP: assert property (@(posedge clk) disable iff (rst)
    take |=> (fill == $past(fill) + CNT_W'(IN_W - OUT_W))); // R2

  AST_UNDERRUN_STICKY: assert property (@(posedge clk) disable iff (rst)
    underrun |=> underrun); // R7

  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
    stall |=> (!out_valid && fill == $past(fill))); // R7
endmodule

// File: rtl/gbx_accum.sv
module gbx_accum #(
  parameter int IN_W  = 67,
  parameter int OUT_W = 40,
  parameter int CNT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             take,
  input  logic             emit,
  input  logic [CNT_W-1:0] fill,
  input  logic [IN_W-1:0]  in_data,
  output logic [OUT_W-1:0] out_data
);
  localparam int BUF_W = IN_W + OUT_W - 1;

  logic [BUF_W-1:0] hold;
  logic [BUF_W-1:0] merged;

  always_comb begin
    merged = hold;
    if (take) merged = merged | (BUF_W'(in_data) << fill);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold     <= '0;
      out_data <= '0;
    end else if (emit) begin
      out_data <= merged[OUT_W-1:0];
      hold     <= merged >> OUT_W;
    end
  end

  AST_IDLE_STABLE: assert property (@(posedge clk) disable iff (rst)
    !emit |=> ($stable(hold) && $stable(out_data))); // R6
endmodule

// File: rtl/lane_tx_gearbox.sv
module lane_tx_gearbox
  import gbx_pkg::*;
#(
  parameter int IN_W  = GBX_IN_W,
  parameter int OUT_W = GBX_OUT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [IN_W-1:0]  in_data,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output logic             underrun
);
  localparam int CNT_W = $clog2(IN_W + OUT_W);

  logic             take;
  logic             emit;
  logic [CNT_W-1:0] fill;

  gbx_ctrl #(.IN_W(IN_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) i_ctrl (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .take(take), .emit(emit), .fill(fill), .out_valid(out_valid),
    .underrun(underrun)
  );

  gbx_accum #(.IN_W(IN_W), .OUT_W(OUT_W), .CNT_W(CNT_W)) i_accum (
    .clk(clk), .rst(rst), .take(take), .emit(emit), .fill(fill),
    .in_data(in_data), .out_data(out_data)
  );

  AST_ACCEPT_EMITS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid); // R4

  AST_BUSY_EMITS: assert property (@(posedge clk) disable iff (rst)
    !in_ready |=> out_valid); // R4
endmodule

// File: tb/test_lane_tx_gearbox.sv
module test_lane_tx_gearbox;
  logic        clk = 1'b0;
  logic        rst = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [66:0] in_data = '0;
  logic        out_valid;
  logic [39:0] out_data;
  logic        underrun;

  int errors = 0;
  int checks = 0;
  bit q[$];
  bit exp_ov = 1'b0;
  bit exp_ur = 1'b0;
  bit primed = 1'b0;
  logic [39:0] exp_od = '0;
  int busy_run = 0;
  int max_held = 0;

  always #2.5 clk = ~clk;

  lane_tx_gearbox i_lane_tx_gearbox (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data),
    .underrun(underrun)
  );

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [66:0] rnd_word();
    logic [95:0] w;
    w = {$urandom, $urandom, $urandom};
    return w[66:0];
  endfunction

  // Called at a falling edge: check outputs, drive inputs, advance model.
  task automatic step(input bit v, input logic [66:0] d, input string tag);
    bit rdy;
    check(out_valid === exp_ov, {tag, " out_valid"}, 64'(out_valid), 64'(exp_ov));
    if (exp_ov) check(out_data === exp_od, {tag, " R3 out_data"}, 64'(out_data), 64'(exp_od));
    check(underrun === exp_ur, "R7 underrun", 64'(underrun), 64'(exp_ur));
    rdy = (q.size() < 40);
    check(in_ready === rdy, "R2 in_ready", 64'(in_ready), 64'(rdy));
    busy_run = in_ready ? 0 : busy_run + 1;
    check(busy_run <= 2, "R5 ready low run", 64'(busy_run), 64'd2);
    in_valid = v;
    in_data  = d;
    if (rdy && v) begin
      for (int i = 0; i < 67; i++) q.push_back(d[i]);
      primed = 1'b1;
    end
    if (q.size() > max_held) max_held = q.size();
    if (q.size() >= 40) begin
      for (int i = 0; i < 40; i++) exp_od[i] = q.pop_front();
      exp_ov = 1'b1;
    end else begin
      exp_ov = 1'b0;
      if (primed) exp_ur = 1'b1;
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    q.delete();
    exp_ov = 1'b0;
    exp_ur = 1'b0;
    primed = 1'b0;
    busy_run = 0;
  endtask

  initial begin
    void'($urandom(32'd4021));
    @(negedge clk);
    do_reset();
    // R1 reset state
    check(out_valid === 1'b0, "R1 out_valid", 64'(out_valid), 64'd0);
    check(underrun === 1'b0, "R1 underrun", 64'(underrun), 64'd0);
    check(in_ready === 1'b1, "R1 in_ready", 64'(in_ready), 64'd1);

    // R6: idle before the first word: no output, no flag
    for (int i = 0; i < 5; i++) step(1'b0, rnd_word(), "R6 idle");

    // R8 / R4: producer always offers a word
    for (int i = 0; i < 400; i++) step(1'b1, rnd_word(), "R8 full rate");
    check(max_held == 106, "R5 peak residue reached", 64'(max_held), 64'd106);

    // R6: junk and valid toggling while not ready, word always ready when needed
    for (int i = 0; i < 600; i++) begin
      bit v;
      v = (q.size() < 40) ? 1'b1 : 1'($urandom_range(0, 1));
      step(v, rnd_word(), "R6 ignore busy");
    end

    // R7: force a stall on a ready cycle
    while (q.size() >= 40) step(1'b1, rnd_word(), "R4 drain");
    step(1'b0, rnd_word(), "R7 stall");
    for (int i = 0; i < 50; i++) step(1'b1, rnd_word(), "R7 after stall");
    check(underrun === 1'b1, "R7 sticky", 64'(underrun), 64'd1);

    // random gaps: stalls allowed
    for (int i = 0; i < 500; i++) step(($urandom_range(0, 9) != 0), rnd_word(), "R3 random gaps");

    // R9: reset mid-stream, then fresh stream
    do_reset();
    check(out_valid === 1'b0, "R9 out_valid after reset", 64'(out_valid), 64'd0);
    check(underrun === 1'b0, "R9 underrun cleared", 64'(underrun), 64'd0);
    check(in_ready === 1'b1, "R9 in_ready after reset", 64'(in_ready), 64'd1);
    step(1'b1, 67'h5_A5A5_0F0F_1234_5678, "R9 restart");
    step(1'b1, 67'h0_FFFF_0000_FFFF_0001, "R9 restart");
    for (int i = 0; i < 200; i++) step(1'b1, rnd_word(), "R9 restart");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule